// File: doc/BRIEF.md
# Banked Memory Address Extender

This block widens the 16-bit address of a small CPU into a 24-bit physical memory address so that an operating system can keep several 64 KB worlds in a larger memory. The logical space is split into two parts. The lower part, starting at address zero, is the banked region. It maps into whichever bank a software-writable bank register selects. The upper part, from a configurable boundary to the top of the 64 KB space, is the common region. It always maps into one fixed bank, so code and data placed there stay in view while software switches banks.

Software selects a bank with an I/O write of the bank number to one designated port. It can read the current value back through the same port. A static two-bit configuration input chooses where the common region begins. The address translation is purely combinational. Only the bank register holds state.

Top module: `bxt_addr_extender`

## Requirements
- R1: `phys_addr[15:0]` always equals `cpu_addr` with no delay.
- R2: When `cpu_addr` is below the common base, `phys_addr[23:16]` equals the current bank register value, combinationally.
- R3: When `cpu_addr` is at or above the common base, `phys_addr[23:16]` equals the parameter `COMMON_BANK` (default 8'h00), whatever the bank register holds.
- R4: `split_cfg` sets the common base: 2'b00 gives 0xC000 (48 KB banked / 16 KB common), 2'b01 gives 0x8000 (32/32), 2'b10 gives 0x4000, and 2'b11 is treated like 2'b00.
- R5: A write loads `io_wdata` into the bank register at the rising clock edge on which `io_wr` is high and `io_port[7:0]` equals the parameter `BANK_PORT` (default 8'h40). The new bank appears on `phys_addr[23:16]` for banked addresses in the cycle after that edge.
- R6: An I/O write whose `io_port[7:0]` differs from `BANK_PORT` leaves the bank register unchanged. Bits `io_port[15:8]` take no part in the port match.
- R7: Synchronous active-high `rst` clears the bank register to 8'h00.
- R8: `io_rdata` shows the bank register while `io_rd` is high and `io_port[7:0]` equals `BANK_PORT`. Otherwise it is 8'h00.
- R9: Every value from 8'h00 to 8'hFF written to the bank port is held and used as the bank, so the banked region can be switched among all 256 banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU logical address |
| split_cfg | input | 2 | Static common-region boundary select |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_port | input | 16 | I/O port address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (bank register on port match) |
| phys_addr | output | 24 | Physical memory address |

## Verification
Translation and read-back are combinational. The bench therefore checks `phys_addr` and `io_rdata` in the same cycle as the inputs that produce them, after the inputs have settled and before the next rising edge. A bank write takes effect one edge later. The bench drives the strobe on a falling edge, lets one rising edge pass, and only then compares banked-region addresses against its updated model. Ignored writes are judged the same way: after the edge, a banked address must still show the old bank.

// File: rtl/bxt_pkg.sv
package bxt_pkg;

    localparam int LADDR_W = 16;
    localparam int BANK_W  = 8;
    localparam int PADDR_W = LADDR_W + BANK_W;

    typedef enum logic [1:0] {
        SPLIT_48_16 = 2'b00,
        SPLIT_32_32 = 2'b01,
        SPLIT_16_48 = 2'b10,
        SPLIT_ALT   = 2'b11
    } split_t;

    typedef struct packed {
        logic [BANK_W-1:0]  upper;
        logic [LADDR_W-1:0] lower;
    } phys_t;

    function automatic logic [LADDR_W-1:0] common_base(input split_t cfg);
        case (cfg)
            SPLIT_32_32: return 16'h8000;
            SPLIT_16_48: return 16'h4000;
            default:     return 16'hC000;
        endcase
    endfunction

endpackage

// File: rtl/bxt_bank_reg.sv
module bxt_bank_reg
    import bxt_pkg::*;
#(
    parameter int             PORT_W       = 16,
    parameter int             MATCH_W      = 8,
    parameter logic [MATCH_W-1:0] BANK_PORT = 8'h40
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               io_wr,
    input  logic               io_rd,
    input  logic [PORT_W-1:0]  io_port,
    input  logic [BANK_W-1:0]  io_wdata,
    output logic [BANK_W-1:0]  bank_q,
    output logic [BANK_W-1:0]  io_rdata
);
    logic port_hit;

    // only the low MATCH_W bits of the port take part in decoding
    assign port_hit = (io_port[MATCH_W-1:0] == BANK_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (io_wr && port_hit) begin
            bank_q <= io_wdata;
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd && port_hit) begin
            io_rdata = bank_q;
        end
    end

endmodule

// File: rtl/bxt_region_decode.sv
module bxt_region_decode
    import bxt_pkg::*;
(
    input  logic [LADDR_W-1:0] addr,
    input  logic [1:0]         split_cfg,
    output logic               in_common
);
    logic [LADDR_W-1:0] base;

    assign base      = common_base(split_t'(split_cfg));
    assign in_common = (addr >= base);

endmodule

// File: rtl/bxt_addr_map.sv
module bxt_addr_map
    import bxt_pkg::*;
#(
    parameter logic [BANK_W-1:0] COMMON_BANK = 8'h00
) (
    input  logic [LADDR_W-1:0] addr,
    input  logic               in_common,
    input  logic [BANK_W-1:0]  bank,
    output phys_t              phys
);
    always_comb begin
        phys.lower = addr;
        phys.upper = in_common ? COMMON_BANK : bank;
    end

endmodule

// File: rtl/bxt_addr_extender.sv
module bxt_addr_extender
    import bxt_pkg::*;
#(
    parameter int                  PORT_W      = 16,
    parameter int                  MATCH_W     = 8,
    parameter logic [MATCH_W-1:0]  BANK_PORT   = 8'h40,
    parameter logic [BANK_W-1:0]   COMMON_BANK = 8'h00
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LADDR_W-1:0]  cpu_addr,
    input  logic [1:0]          split_cfg,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [PORT_W-1:0]   io_port,
    input  logic [BANK_W-1:0]   io_wdata,
    output logic [BANK_W-1:0]   io_rdata,
    output logic [PADDR_W-1:0]  phys_addr
);
    logic [BANK_W-1:0] bank_q;
    logic              in_common;
    phys_t             phys;

    bxt_bank_reg #(
        .PORT_W    (PORT_W),
        .MATCH_W   (MATCH_W),
        .BANK_PORT (BANK_PORT)
    ) u_reg (
        .clk      (clk),
        .rst      (rst),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_port  (io_port),
        .io_wdata (io_wdata),
        .bank_q   (bank_q),
        .io_rdata (io_rdata)
    );

    bxt_region_decode u_dec (
        .addr      (cpu_addr),
        .split_cfg (split_cfg),
        .in_common (in_common)
    );

    bxt_addr_map #(
        .COMMON_BANK (COMMON_BANK)
    ) u_map (
        .addr      (cpu_addr),
        .in_common (in_common),
        .bank      (bank_q),
        .phys      (phys)
    );

    assign phys_addr = phys;

endmodule

// File: rtl/bxt_addr_extender_chk.sv
module bxt_addr_extender_chk
    import bxt_pkg::*;
#(
    parameter int                  PORT_W      = 16,
    parameter int                  MATCH_W     = 8,
    parameter logic [MATCH_W-1:0]  BANK_PORT   = 8'h40,
    parameter logic [BANK_W-1:0]   COMMON_BANK = 8'h00
) (
    input logic                clk,
    input logic                rst,
    input logic [LADDR_W-1:0]  cpu_addr,
    input logic [1:0]          split_cfg,
    input logic                io_wr,
    input logic                io_rd,
    input logic [PORT_W-1:0]   io_port,
    input logic [BANK_W-1:0]   io_wdata,
    input logic [BANK_W-1:0]   io_rdata,
    input logic [PADDR_W-1:0]  phys_addr,
    input logic [BANK_W-1:0]   bank_q
);
    logic [LADDR_W-1:0] chk_base;
    logic               chk_hit;

    always_comb begin
        case (split_cfg)
            2'b01:   chk_base = 16'h8000;
            2'b10:   chk_base = 16'h4000;
            default: chk_base = 16'hC000;
        endcase
    end
    assign chk_hit = (io_port[MATCH_W-1:0] == BANK_PORT);

    AST_LOW_PASS: assert property (@(posedge clk) disable iff (rst)
        phys_addr[LADDR_W-1:0] == cpu_addr); // R1
    AST_BANKED_SEL: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr < chk_base) |-> (phys_addr[PADDR_W-1:LADDR_W] == bank_q)); // R2
    AST_COMMON_FIXED: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr >= chk_base) |-> (phys_addr[PADDR_W-1:LADDR_W] == COMMON_BANK)); // R3
    AST_BANK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (io_wr && chk_hit) |=> (bank_q == $past(io_wdata))); // R5
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && chk_hit) |=> $stable(bank_q)); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (bank_q == '0)); // R7
    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
        io_rdata == ((io_rd && chk_hit) ? bank_q : '0)); // R8

endmodule

bind bxt_addr_extender bxt_addr_extender_chk #(
    .PORT_W      (PORT_W),
    .MATCH_W     (MATCH_W),
    .BANK_PORT   (BANK_PORT),
    .COMMON_BANK (COMMON_BANK)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .split_cfg (split_cfg),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_port   (io_port),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .phys_addr (phys_addr),
    .bank_q    (bank_q)
);

// File: tb/tb_bxt_addr_extender.sv
module tb_bxt_addr_extender;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [1:0]  split_cfg = 2'b00;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_port = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [23:0] phys_addr;

    int total = 0;
    int bad = 0;
    logic [7:0] model_bank = 8'h00;
    bit done = 0;

    always #2 clk = ~clk;

    bxt_addr_extender dut (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .split_cfg (split_cfg),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_port   (io_port),
        .io_wdata  (io_wdata),
        .io_rdata  (io_rdata),
        .phys_addr (phys_addr)
    );

    function automatic logic [15:0] exp_base(input logic [1:0] cfg);
        if (cfg == 2'b01) return 16'h8000;
        if (cfg == 2'b10) return 16'h4000;
        return 16'hC000;
    endfunction

    function automatic logic [23:0] exp_phys(input logic [15:0] a, input logic [1:0] cfg,
                                             input logic [7:0] bank);
        return {(a >= exp_base(cfg)) ? 8'h00 : bank, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs change on the falling edge; outputs are sampled 1 ns later
    task automatic probe(input string req, input logic [15:0] a, input logic [1:0] cfg);
        @(negedge clk);
        cpu_addr  = a;
        split_cfg = cfg;
        #1;
        check(req, {8'h00, phys_addr}, {8'h00, exp_phys(a, cfg, model_bank)});
    endtask

    task automatic io_write(input logic [15:0] port, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_port = port; io_wdata = d;
        @(posedge clk);
        if (port[7:0] == 8'h40) model_bank = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input string req, input logic [15:0] port);
        @(negedge clk);
        io_rd = 1'b1; io_port = port;
        #1;
        check(req, {24'h0, io_rdata}, {24'h0, (port[7:0] == 8'h40) ? model_bank : 8'h00});
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R7: bank register cleared by reset
        probe("R7", 16'h1234, 2'b00);
        io_read("R7", 16'h0040);

        // R2/R5: load a bank, visible after one edge
        io_write(16'h0040, 8'hA5);
        probe("R5", 16'h0000, 2'b00);
        probe("R2", 16'hBFFF, 2'b00);
        // R3: common region ignores bank register
        probe("R3", 16'hC000, 2'b00);
        probe("R3", 16'hFFFF, 2'b00);
        // R4: each boundary choice
        probe("R4", 16'h7FFF, 2'b01);
        probe("R4", 16'h8000, 2'b01);
        probe("R4", 16'h3FFF, 2'b10);
        probe("R4", 16'h4000, 2'b10);
        probe("R4", 16'hBFFF, 2'b11);
        probe("R4", 16'hC000, 2'b11);
        // R1: low bits pass through
        probe("R1", 16'h5A5A, 2'b01);
        // R6: other ports ignored; upper port byte does not matter
        io_write(16'h0041, 8'h3C);
        probe("R6", 16'h0100, 2'b00);
        io_write(16'h4000, 8'h77);
        probe("R6", 16'h0200, 2'b00);
        io_write(16'hFF40, 8'h5E);
        probe("R6", 16'h0300, 2'b00);
        // R8: read-back on match, zero elsewhere
        io_read("R8", 16'h0040);
        io_read("R8", 16'h0042);
        // R9: extreme bank values
        io_write(16'h0040, 8'hFF);
        probe("R9", 16'h0001, 2'b01);
        io_write(16'h0040, 8'h00);
        probe("R9", 16'h0001, 2'b01);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: io_write({$urandom_range(0, 255), 8'h40}, 8'($urandom()));
                1: io_write(16'($urandom()), 8'($urandom()));
                2: io_read("R8", ($urandom_range(0, 1) != 0) ? 16'h0040 : 16'($urandom()));
                default: probe("R2/R3", 16'($urandom()), 2'($urandom()));
            endcase
        end

        // R7: reset mid-run clears a loaded bank
        io_write(16'h0040, 8'h9C);
        @(negedge clk) rst = 1'b1;
        @(posedge clk);
        model_bank = 8'h00;
        @(negedge clk) rst = 1'b0;
        probe("R7", 16'h0010, 2'b00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule